// File: doc/BRIEF.md
# Delayed Register-Update Queue

This block holds a small ring of register writes whose effect is postponed. A producer hands over one update per cycle: a destination register, either a single-bit operation or a whole-register write, a value, a 32- or 64-bit width and a delay in ticks. Every time the `tick_i` strobe is high, each waiting entry counts its delay down by one. An entry whose delay runs out writes an internal file of eight 64-bit registers. The file has one combinational read port. The block models state whose change becomes visible some instructions after the operation that caused it, such as condition flags or late register writes.

Each entry counts down on its own and takes effect as soon as its own delay expires, whatever its position in the ring. Its slot, however, is released only from the head of the ring. An entry that expires while an older entry is still waiting is marked finished. It is released later, together with the head, in the tick that frees the head. A sticky fatal flag reports a ring whose pointers disagree with its live-entry count.

Top module: `delayed_update_queue`

## Requirements
- R1: After reset every register of the file reads zero, `enq_ready_o` is 1 and `fatal_o` is 0.
- R2: `enq_ready_o` is 0 exactly when SLOTS entries are live. An update is taken only in a cycle with `enq_valid_i` and `enq_ready_o` both high, so an offer made while the ring is full is dropped and never written.
- R3: An entry taken with delay D of 1 or more writes the file at the clock edge of the D-th cycle with `tick_i` high after the cycle that took it. Delay 0 behaves as delay 1. Cycles with `tick_i` low change neither the file nor the delays.
- R4: An entry taken in a cycle where `tick_i` is also high is not aged by that tick.
- R5: A whole-register update (`enq_bit_mode_i`=0) with `enq_wide_i`=1 replaces all 64 bits of the destination.
- R6: A whole-register update with `enq_wide_i`=0 replaces bits 31:0 only and leaves bits 63:32 unchanged.
- R7: A single-bit update (`enq_bit_mode_i`=1) sets the selected bit when the value is nonzero and clears only that bit when the value is zero. With `enq_wide_i`=1 the bit index is `enq_bit_i[5:0]`. With `enq_wide_i`=0 it is `enq_bit_i[4:0]`.
- R8: An entry that expires behind a still-waiting head is applied at once, but its slot stays occupied. When the head expires, the head and every following entry that has already expired are released in the same tick.
- R9: Every entry is applied exactly once, even if it stays in the ring for many ticks after it expired.
- R10: Entries expiring in the same tick are applied in ring order from the head, so a later entry to the same register takes effect on top of an earlier one.
- R11: `fatal_o` rises when the in and out pointers differ while the live count is zero, and then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Aging strobe: one delay step per high cycle |
| enq_valid_i | input | 1 | An update is offered |
| enq_ready_o | output | 1 | The ring has a free slot |
| enq_dst_i | input | 3 | Destination register index |
| enq_bit_mode_i | input | 1 | 1: single-bit set/clear, 0: whole-register write |
| enq_bit_i | input | 6 | Bit index for single-bit updates |
| enq_val_i | input | 64 | Value to write; for bit updates, nonzero means set |
| enq_wide_i | input | 1 | 1: 64-bit update, 0: 32-bit update |
| enq_dly_i | input | 4 | Delay in ticks |
| rd_idx_i | input | 3 | Read port register index |
| rd_data_o | output | 64 | Contents of the selected register |
| fatal_o | output | 1 | Sticky ring-inconsistency flag |

## Verification
On every cycle the bound checker enforces that the file receives no update without a tick and that the live count stays within the ring size. It also checks that the count moves only through an accepted offer or a tick, that the out pointer advances by exactly the number of slots released, and that the fatal flag is sticky. Only the bench's scenarios can show the actual register contents: the tick at which an entry lands, half-word and single-bit merging, ring order among same-tick expiries, and that an early-expired entry is applied exactly once while its slot is held until the head leaves. The bench also shows that an offer made while the ring is full leaves no trace.

// File: rtl/dq_pkg.sv
package dq_pkg;
    parameter int DQ_NREG   = 8;
    parameter int DQ_RIDX_W = $clog2(DQ_NREG);
    parameter int DQ_DW     = 64;
    parameter int DQ_BIT_W  = $clog2(DQ_DW);
    parameter int DQ_DLY_W  = 4;

    // One pending update as handed to the register file
    typedef struct packed {
        logic [DQ_RIDX_W-1:0] dst;
        logic                 bit_mode;
        logic [DQ_BIT_W-1:0]  bitn;
        logic [DQ_DW-1:0]     val;
        logic                 wide;
    } dq_upd_t;

    // One ring slot
    typedef struct packed {
        dq_upd_t             upd;
        logic [DQ_DLY_W-1:0] dly;
        logic                occ;
        logic                done;
    } dq_slot_t;
endpackage

// File: rtl/dq_regfile.sv
module dq_regfile
    import dq_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SLOTS-1:0]     upd_vld_i,
    input  dq_upd_t              upd_i [SLOTS],
    input  logic [DQ_RIDX_W-1:0] rd_idx_i,
    output logic [DQ_DW-1:0]     rd_data_o
);
    localparam int HALF = DQ_DW / 2;

    logic [DQ_DW-1:0] regs_q [DQ_NREG];
    logic [DQ_DW-1:0] regs_d [DQ_NREG];

    // Updates are merged in ring order: a later one sees the earlier result
    always_comb begin
        logic [DQ_DW-1:0]    r;
        logic [DQ_DW-1:0]    mask;
        logic [DQ_BIT_W-1:0] b;
        regs_d = regs_q;
        for (int k = 0; k < SLOTS; k++) begin
            r    = '0;
            mask = '0;
            b    = '0;
            if (upd_vld_i[k]) begin
                r = regs_d[upd_i[k].dst];
                if (upd_i[k].bit_mode) begin
                    b    = upd_i[k].wide ? upd_i[k].bitn
                                         : {1'b0, upd_i[k].bitn[DQ_BIT_W-2:0]};
                    mask = {{(DQ_DW-1){1'b0}}, 1'b1} << b;
                    r    = (upd_i[k].val != '0) ? (r | mask) : (r & ~mask);
                end else if (upd_i[k].wide) begin
                    r = upd_i[k].val;
                end else begin
                    r = {r[DQ_DW-1:HALF], upd_i[k].val[HALF-1:0]};
                end
                regs_d[upd_i[k].dst] = r;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DQ_NREG; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < DQ_NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    assign rd_data_o = regs_q[rd_idx_i];
endmodule

// File: rtl/dq_ring.sv
module dq_ring
    import dq_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    parameter int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                enq_valid_i,
    input  dq_upd_t             enq_upd_i,
    input  logic [DQ_DLY_W-1:0] enq_dly_i,
    output logic                enq_ready_o,
    output logic [SLOTS-1:0]    upd_vld_o,
    output dq_upd_t             upd_o [SLOTS],
    output logic [CNT_W-1:0]    total_o,
    output logic [PTR_W-1:0]    head_o,
    output logic                fatal_o
);
    typedef struct packed {
        dq_slot_t [SLOTS-1:0] slot;
        logic [PTR_W-1:0]     inp;
        logic [PTR_W-1:0]     outp;
        logic [CNT_W-1:0]     total;
        logic                 fatal;
    } ring_t;

    ring_t st_q, st_d;

    assign enq_ready_o = (st_q.total != CNT_W'(SLOTS));

    always_comb begin
        int   nfree;
        int   idx;
        logic chain;
        logic expire;
        logic fin;
        st_d   = st_q;
        nfree  = 0;
        idx    = 0;
        chain  = 1'b1;
        expire = 1'b0;
        fin    = 1'b0;
        upd_vld_o = '0;
        for (int k = 0; k < SLOTS; k++) upd_o[k] = '0;

        // Aging walk from the head over the live entries
        if (tick_i && st_q.total != '0) begin
            for (int k = 0; k < SLOTS; k++) begin
                idx = (int'(st_q.outp) + k) % SLOTS;
                if (k < int'(st_q.total)) begin
                    expire = 1'b0;
                    if (st_q.slot[idx].occ && !st_q.slot[idx].done) begin
                        if (st_q.slot[idx].dly <= DQ_DLY_W'(1)) begin
                            expire                 = 1'b1;
                            st_d.slot[idx].dly     = '0;
                            upd_vld_o[k]           = 1'b1;
                            upd_o[k]               = st_q.slot[idx].upd;
                        end else begin
                            st_d.slot[idx].dly = st_q.slot[idx].dly - 1'b1;
                        end
                    end
                    fin = st_q.slot[idx].occ && (st_q.slot[idx].done || expire);
                    if (chain && fin) begin
                        st_d.slot[idx].occ  = 1'b0;
                        st_d.slot[idx].done = 1'b0;
                        nfree++;
                    end else begin
                        chain = 1'b0;
                        if (expire) st_d.slot[idx].done = 1'b1;
                    end
                end
            end
            st_d.outp  = PTR_W'((int'(st_q.outp) + nfree) % SLOTS);
            st_d.total = st_q.total - CNT_W'(nfree);
        end

        if (st_q.inp != st_q.outp && st_q.total == '0) st_d.fatal = 1'b1;

        // New entry lands in a free slot the walk does not touch
        if (enq_valid_i && enq_ready_o) begin
            st_d.slot[st_q.inp].upd  = enq_upd_i;
            st_d.slot[st_q.inp].dly  = enq_dly_i;
            st_d.slot[st_q.inp].occ  = 1'b1;
            st_d.slot[st_q.inp].done = 1'b0;
            st_d.inp   = PTR_W'((int'(st_q.inp) + 1) % SLOTS);
            st_d.total = st_d.total + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign total_o = st_q.total;
    assign head_o  = st_q.outp;
    assign fatal_o = st_q.fatal;
endmodule

// File: rtl/delayed_update_queue.sv
module delayed_update_queue
    import dq_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 enq_valid_i,
    output logic                 enq_ready_o,
    input  logic [DQ_RIDX_W-1:0] enq_dst_i,
    input  logic                 enq_bit_mode_i,
    input  logic [DQ_BIT_W-1:0]  enq_bit_i,
    input  logic [DQ_DW-1:0]     enq_val_i,
    input  logic                 enq_wide_i,
    input  logic [DQ_DLY_W-1:0]  enq_dly_i,
    input  logic [DQ_RIDX_W-1:0] rd_idx_i,
    output logic [DQ_DW-1:0]     rd_data_o,
    output logic                 fatal_o
);
    dq_upd_t          enq_upd;
    logic [SLOTS-1:0] q_vld;
    dq_upd_t          q_upd [SLOTS];
    logic [CNT_W-1:0] q_total;
    logic [PTR_W-1:0] q_head;

    assign enq_upd = '{dst: enq_dst_i, bit_mode: enq_bit_mode_i, bitn: enq_bit_i,
                       val: enq_val_i, wide: enq_wide_i};

    dq_ring #(.SLOTS(SLOTS), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .enq_valid_i (enq_valid_i),
        .enq_upd_i   (enq_upd),
        .enq_dly_i   (enq_dly_i),
        .enq_ready_o (enq_ready_o),
        .upd_vld_o   (q_vld),
        .upd_o       (q_upd),
        .total_o     (q_total),
        .head_o      (q_head),
        .fatal_o     (fatal_o)
    );

    dq_regfile #(.SLOTS(SLOTS)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_vld_i (q_vld),
        .upd_i     (q_upd),
        .rd_idx_i  (rd_idx_i),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: rtl/dq_chk.sv
module dq_chk #(
    parameter int SLOTS = 4,
    parameter int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    parameter int CNT_W = $clog2(SLOTS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             enq_fire,
    input logic [CNT_W-1:0] total,
    input logic [PTR_W-1:0] head,
    input logic [SLOTS-1:0] upd_vld,
    input logic             fatal
);
    // R3: the file sees no update in a cycle without a tick
    a_r3_no_update_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> (upd_vld == '0));

    // R3: the live count holds with neither tick nor accepted offer
    a_r3_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !enq_fire) |=> $stable(total));

    // R2: the live count never exceeds the ring size
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(total) <= SLOTS);

    // R2: an accepted offer without a tick adds exactly one entry
    a_r2_accept_adds: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_fire && !tick) |=> (int'(total) == int'($past(total)) + 1));

    // R8: the head moves by exactly the number of released slots
    a_r8_head_tracks_release: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (((int'(head) - int'($past(head)) + SLOTS) % SLOTS) ==
                  ((int'($past(total)) + int'($past(enq_fire)) - int'(total)) % SLOTS)));

    // R11: the fatal flag is sticky
    a_r11_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal);
endmodule

bind delayed_update_queue dq_chk #(.SLOTS(SLOTS)) u_dq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_i),
    .enq_fire (enq_valid_i && enq_ready_o),
    .total    (q_total),
    .head     (q_head),
    .upd_vld  (q_vld),
    .fatal    (fatal_o)
);

// File: tb/test_delayed_update_queue.sv
module test_delayed_update_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        enq_valid_i = 1'b0;
    logic        enq_ready_o;
    logic [2:0]  enq_dst_i = '0;
    logic        enq_bit_mode_i = 1'b0;
    logic [5:0]  enq_bit_i = '0;
    logic [63:0] enq_val_i = '0;
    logic        enq_wide_i = 1'b0;
    logic [3:0]  enq_dly_i = '0;
    logic [2:0]  rd_idx_i = '0;
    logic [63:0] rd_data_o;
    logic        fatal_o;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;  // 125 MHz

    delayed_update_queue i_delayed_update_queue (.*);

    typedef struct {
        logic [2:0]  idx;
        logic [63:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb[$];

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver side of the scoreboard
    task automatic expect_reg(logic [2:0] idx, logic [63:0] exp, string tag);
        sb_item_t it;
        it.idx = idx;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic drain();
        wait (sb.size() == 0);
        #3;
    endtask

    // Monitor: reads the file through the read port and compares
    initial begin
        sb_item_t it;
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                it = sb.pop_front();
                rd_idx_i = it.idx;
                #1;
                chk(it.tag, rd_data_o, it.exp);
            end
        end
    end

    task automatic cyc(bit en, bit tk, logic [2:0] dst, bit bm, logic [5:0] bn,
                       logic [63:0] val, bit wide, logic [3:0] dly);
        enq_valid_i    = en;
        tick_i         = tk;
        enq_dst_i      = dst;
        enq_bit_mode_i = bm;
        enq_bit_i      = bn;
        enq_val_i      = val;
        enq_wide_i     = wide;
        enq_dly_i      = dly;
        @(posedge clk);
        #1;
        enq_valid_i = 1'b0;
        tick_i      = 1'b0;
    endtask

    task automatic tk();
        cyc(1'b0, 1'b1, '0, 1'b0, '0, '0, 1'b0, '0);
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, '0, 1'b0, '0, '0, 1'b0, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 8; i++) expect_reg(3'(i), 64'h0, "R1 reset register");
        drain();
        chk("R1 ready after reset", 64'(enq_ready_o), 64'h1);
        chk("R1 fatal after reset", 64'(fatal_o), 64'h0);

        // R3/R5: 64-bit write with delay 3
        cyc(1'b1, 1'b0, 3'd1, 1'b0, '0, 64'h1122334455667788, 1'b1, 4'd3);
        tk(); tk();
        expect_reg(3'd1, 64'h0, "R3 not yet after two ticks");
        drain();
        tk();
        expect_reg(3'd1, 64'h1122334455667788, "R5 whole write on third tick");
        drain();

        // R6: 32-bit whole write keeps the upper half
        cyc(1'b1, 1'b0, 3'd1, 1'b0, '0, 64'hAAAABBBBCCCCDDDD, 1'b0, 4'd1);
        tk();
        expect_reg(3'd1, 64'h11223344CCCCDDDD, "R6 low half only");
        drain();

        // R7: bit set, then bit clear of a single bit
        cyc(1'b1, 1'b0, 3'd2, 1'b1, 6'd40, 64'h1, 1'b1, 4'd1);
        tk();
        expect_reg(3'd2, 64'h0000010000000000, "R7 bit 40 set");
        cyc(1'b1, 1'b0, 3'd3, 1'b0, '0, 64'hFFFFFFFFFFFFFFFF, 1'b1, 4'd1);
        tk();
        cyc(1'b1, 1'b0, 3'd3, 1'b1, 6'd5, 64'h0, 1'b1, 4'd1);
        tk();
        expect_reg(3'd3, 64'hFFFFFFFFFFFFFFDF, "R7 clear only bit 5");
        // R7: 32-bit bit update uses the low five index bits (37 -> 5)
        cyc(1'b1, 1'b0, 3'd2, 1'b1, 6'd37, 64'h100, 1'b0, 4'd1);
        tk();
        expect_reg(3'd2, 64'h0000010000000020, "R7 narrow bit index wraps");
        drain();

        // R3: delay 0 acts as 1
        cyc(1'b1, 1'b0, 3'd0, 1'b0, '0, 64'h5A, 1'b1, 4'd0);
        tk();
        expect_reg(3'd0, 64'h5A, "R3 delay zero applies on first tick");
        drain();

        // R4: enqueue in a tick cycle is not aged by it
        cyc(1'b1, 1'b1, 3'd0, 1'b0, '0, 64'h77, 1'b1, 4'd1);
        expect_reg(3'd0, 64'h5A, "R4 not aged by the enqueue tick");
        drain();
        tk();
        expect_reg(3'd0, 64'h77, "R4 applied on the next tick");
        drain();

        // R3: cycles without tick change nothing
        cyc(1'b1, 1'b0, 3'd0, 1'b0, '0, 64'h99, 1'b1, 4'd1);
        idle(); idle(); idle();
        expect_reg(3'd0, 64'h77, "R3 no effect without tick");
        drain();
        tk();
        expect_reg(3'd0, 64'h99, "R3 applied once ticked");
        drain();

        // R8/R9/R10: expiry behind a waiting head, across the ring wrap
        cyc(1'b1, 1'b0, 3'd4, 1'b0, '0, 64'hA, 1'b1, 4'd5);
        cyc(1'b1, 1'b0, 3'd4, 1'b0, '0, 64'hB, 1'b1, 4'd1);
        cyc(1'b1, 1'b0, 3'd6, 1'b0, '0, 64'hFF, 1'b1, 4'd2);
        cyc(1'b1, 1'b0, 3'd6, 1'b1, 6'd0, 64'h0, 1'b1, 4'd2);
        chk("R2 ready low when full", 64'(enq_ready_o), 64'h0);
        // R2: offer while full is dropped
        cyc(1'b1, 1'b0, 3'd7, 1'b0, '0, 64'h123, 1'b1, 4'd1);
        tk();
        expect_reg(3'd4, 64'hB, "R8 non-head entry applied at once");
        drain();
        chk("R8 slot held behind waiting head", 64'(enq_ready_o), 64'h0);
        tk();
        expect_reg(3'd6, 64'hFE, "R10 later same-tick entry wins");
        drain();
        tk(); tk();
        chk("R8 still full before head expires", 64'(enq_ready_o), 64'h0);
        expect_reg(3'd4, 64'hB, "R8 head not yet applied");
        drain();
        tk();
        expect_reg(3'd4, 64'hA, "R9 expired entry not applied again");
        drain();
        chk("R8 head release frees finished entries", 64'(enq_ready_o), 64'h1);
        tk(); tk();
        expect_reg(3'd7, 64'h0, "R2 dropped offer never written");
        expect_reg(3'd6, 64'hFE, "R9 no reapplication after release");
        drain();

        // R2: ring refills to full after the wrap
        for (int i = 0; i < 4; i++)
            cyc(1'b1, 1'b0, 3'd5, 1'b0, '0, 64'(i + 1), 1'b1, 4'd1);
        chk("R2 full again after four offers", 64'(enq_ready_o), 64'h0);
        tk();
        expect_reg(3'd5, 64'h4, "R10 last of four in ring order");
        drain();
        chk("R2 ready after all released", 64'(enq_ready_o), 64'h1);

        chk("R11 fatal stays low", 64'(fatal_o), 64'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule